// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block sits behind a host configuration space and turns two 32-bit configuration registers into transactions on an internal sideband bus. Software stages data in a data register and then writes a command word into a control register. The command word names an opcode, a destination port, a register offset and four byte enables. For a write, the staged data travels to the target. For a read, the target's value lands in the data register once the transaction completes.

One sideband target is built in. It answers on port 3 and holds three memory-region descriptors, each made of a low and a high boundary register. The bottom nibble of each boundary register is status or lock information rather than address. A write to a region's low register locks that region until reset. Later writes to either register of a locked region are refused and flagged, while reads still work.

A busy flag shows a transaction in flight. A sticky error flag records refused, malformed or misdirected commands until reset.

Top module: `sbb_bridge`

## Requirements
- R1: A configuration write to offset 0xD0 loads the control register and one to offset 0xD4 loads the data register. `cfgRdData` returns the control register for `cfgAddr` 0xD0, the data register for 0xD4, and zero for any other offset, in the same cycle.
- R2: The command word is decoded as opcode [31:24], port [23:16], register offset [15:8] and byte enables [7:4], with [3:0] carried but unused. The control register reads back the last accepted command word unchanged.
- R3: Opcode 0xE0 on port 3 writes the data register's contents into the addressed target register.
- R4: Opcode 0xD0 on port 3 reads the addressed target register. After busy falls, the data register holds that value.
- R5: Byte enable bit k (command bit 4+k) gates data byte k (bits 8k+7:8k) of a write. Target bytes whose enable is clear keep their old value.
- R6: Target offsets 0x10+2k and 0x11+2k are the low and high boundary registers of region k, for k = 0..2. They reset to zero and store all 32 bits, including the bottom nibble.
- R7: Any write to a region's low register locks that region until reset. Later writes to either register of that region leave it unchanged and set the error flag, and reads still return the stored values. Other regions are unaffected.
- R8: An opcode other than 0xD0 or 0xE0 starts no transaction. Busy stays low, the error flag is set and the data register is unchanged.
- R9: A valid opcode to a port other than 3 completes at once with busy staying low, and sets the error flag. For a read, the data register becomes 0xFFFFFFFF.
- R10: A command to port 3 with an offset outside 0x10..0x15 sets the error flag, changes no target register, and for a read returns 0xFFFFFFFF in the data register.
- R11: An accepted command raises busy in the cycle after the control write, for exactly two cycles. A control write while busy is dropped: the control register and the target keep their state and the error flag is set.
- R12: Reset clears both configuration registers, busy and the error flag. Once set, the error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration register offset, used for writes and reads |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for `cfgAddr` |
| busy | output | 1 | Sideband transaction in flight |
| errFlag | output | 1 | Sticky error flag |

## Verification
The command path is tried with full-word writes, partial byte-enable patterns (0x5 and 0xA) and read-backs. These separate correct byte gating from whole-word overwrite, and separate read-data capture from a stale data register. Writes to unlocked high registers, locked low and high registers, and a different region separate a per-region lock from a global one. A reset in between shows that the lock does not survive reset. Bad opcodes, foreign ports, unknown offsets and back-to-back commands each tell an early-completing error path apart from a real transaction, through the busy timing, the error flag and the 0xFFFFFFFF read value.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam logic [7:0] OP_READ      = 8'hD0;
  localparam logic [7:0] OP_WRITE     = 8'hE0;
  localparam logic [7:0] CFG_CTRL_OFF = 8'hD0;
  localparam logic [7:0] CFG_DATA_OFF = 8'hD4;

  typedef struct packed {
    logic mcrLoad;
    logic mdrFromCfg;
    logic mdrFromResp;
    logic mdrOnes;
    logic errSet;
  } ctlStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} ctlState_t;
endpackage

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
  import sbb_pkg::*;
#(
  parameter logic [7:0] PORT_ID = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  input  logic [7:0]  newOp,
  input  logic [7:0]  newPort,
  input  logic        curIsRead,
  input  logic        sbAck,
  input  logic        sbErr,
  output ctlStrobes_t strb,
  output logic        sbReq,
  output logic        busy
);
  ctlState_t stateQ, stateD;
  logic ctrlHit, dataHit, opOk;

  assign ctrlHit = cfgWrEn && (cfgAddr == CFG_CTRL_OFF);
  assign dataHit = cfgWrEn && (cfgAddr == CFG_DATA_OFF);
  assign opOk    = (newOp == OP_READ) || (newOp == OP_WRITE);

  always_comb begin
    strb = '0;
    stateD = stateQ;
    strb.mdrFromCfg = dataHit;
    case (stateQ)
      ST_IDLE: begin
        if (ctrlHit) begin
          strb.mcrLoad = 1'b1;
          if (!opOk) begin
            strb.errSet = 1'b1;
          end else if (newPort != PORT_ID) begin
            strb.errSet = 1'b1;
            strb.mdrOnes = (newOp == OP_READ);
          end else begin
            stateD = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        stateD = ST_WAIT;
        if (ctrlHit) strb.errSet = 1'b1;
      end
      default: begin
        if (ctrlHit) strb.errSet = 1'b1;
        if (sbAck) begin
          stateD = ST_IDLE;
          if (sbErr) strb.errSet = 1'b1;
          if (curIsRead) strb.mdrFromResp = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign sbReq = (stateQ == ST_REQ);
  assign busy  = (stateQ != ST_IDLE);

  // R11
  ack_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sbAck |=> !busy);

  // R11
  req_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sbReq |=> (sbAck && busy));
endmodule

// File: rtl/sbb_datapath.sv
module sbb_datapath
  import sbb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStrobes_t strb,
  input  logic        busy,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgWrData,
  input  logic [31:0] sbRdata,
  output logic [31:0] cfgRdData,
  output logic        sbWrite,
  output logic [7:0]  sbOffset,
  output logic [3:0]  sbBe,
  output logic [31:0] sbWdata,
  output logic        curIsRead,
  output logic        errFlag
);
  logic [31:0] mcrQ, mdrQ;
  logic        errQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcrQ <= '0;
      mdrQ <= '0;
      errQ <= 1'b0;
    end else begin
      if (strb.mcrLoad) mcrQ <= cfgWrData;
      if (strb.mdrFromResp)     mdrQ <= sbRdata;
      else if (strb.mdrOnes)    mdrQ <= '1;
      else if (strb.mdrFromCfg) mdrQ <= cfgWrData;
      if (strb.errSet) errQ <= 1'b1;
    end
  end

  always_comb begin
    case (cfgAddr)
      CFG_CTRL_OFF: cfgRdData = mcrQ;
      CFG_DATA_OFF: cfgRdData = mdrQ;
      default:      cfgRdData = '0;
    endcase
  end

  assign sbWrite   = (mcrQ[31:24] == OP_WRITE);
  assign curIsRead = (mcrQ[31:24] == OP_READ);
  assign sbOffset  = mcrQ[15:8];
  assign sbBe      = mcrQ[7:4];
  assign sbWdata   = mdrQ;
  assign errFlag   = errQ;

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errQ |=> errQ);

  // R11
  mcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfgWrEn && cfgAddr == CFG_CTRL_OFF) |=> ($stable(mcrQ) && errQ));
endmodule

// File: rtl/sbb_target.sv
module sbb_target #(
  parameter int         NUM_REGIONS = 3,
  parameter logic [7:0] BASE_OFF    = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sbReq,
  input  logic        sbWrite,
  input  logic [7:0]  sbOffset,
  input  logic [3:0]  sbBe,
  input  logic [31:0] sbWdata,
  output logic        sbAck,
  output logic        sbErr,
  output logic [31:0] sbRdata
);
  localparam int NUM_REGS = 2 * NUM_REGIONS;
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][31:0] boundQ;
  logic [NUM_REGIONS-1:0]    lockQ;
  logic [7:0]       relOff;
  logic             inRange, regionLocked;
  logic [IDX_W-1:0] regIdx, regionIdx;
  logic [31:0]      merged;

  assign relOff    = sbOffset - BASE_OFF;
  assign inRange   = (sbOffset >= BASE_OFF) && (int'(relOff) < NUM_REGS);
  assign regIdx    = relOff[IDX_W-1:0];
  assign regionIdx = regIdx >> 1;
  assign regionLocked = inRange && lockQ[regionIdx];

  for (genvar b = 0; b < 4; b++) begin : g_byteMerge
    assign merged[b*8 +: 8] = sbBe[b] ? sbWdata[b*8 +: 8] : boundQ[regIdx][b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boundQ  <= '0;
      lockQ   <= '0;
      sbAck   <= 1'b0;
      sbErr   <= 1'b0;
      sbRdata <= '0;
    end else begin
      sbAck <= sbReq;
      if (sbReq) begin
        if (!inRange) begin
          sbErr   <= 1'b1;
          sbRdata <= '1;
        end else if (sbWrite) begin
          sbRdata <= boundQ[regIdx];
          if (regionLocked) begin
            sbErr <= 1'b1;
          end else begin
            sbErr <= 1'b0;
            boundQ[regIdx] <= merged;
            if (!regIdx[0]) lockQ[regionIdx] <= 1'b1;
          end
        end else begin
          sbErr   <= 1'b0;
          sbRdata <= boundQ[regIdx];
        end
      end
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_lockChk
    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockQ[r] |=> lockQ[r]);
  end

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbReq && sbWrite && regionLocked) |=> ($stable(boundQ) && sbErr));

  // R10
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbReq && !inRange) |=> ($stable(boundQ) && sbErr && sbRdata == 32'hFFFF_FFFF));
endmodule

// File: rtl/sbb_bridge.sv
module sbb_bridge
  import sbb_pkg::*;
#(
  parameter logic [7:0] PORT_ID     = 8'h03,
  parameter int         NUM_REGIONS = 3,
  parameter logic [7:0] BASE_OFF    = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        busy,
  output logic        errFlag
);
  ctlStrobes_t strb;
  logic        sbReq, sbAck, sbErr, sbWrite, curIsRead;
  logic [7:0]  sbOffset;
  logic [3:0]  sbBe;
  logic [31:0] sbWdata, sbRdata;

  sbb_ctrl #(.PORT_ID(PORT_ID)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .newOp(cfgWrData[31:24]), .newPort(cfgWrData[23:16]),
    .curIsRead(curIsRead), .sbAck(sbAck), .sbErr(sbErr),
    .strb(strb), .sbReq(sbReq), .busy(busy)
  );

  sbb_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busy(busy),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .sbRdata(sbRdata), .cfgRdData(cfgRdData), .sbWrite(sbWrite),
    .sbOffset(sbOffset), .sbBe(sbBe), .sbWdata(sbWdata),
    .curIsRead(curIsRead), .errFlag(errFlag)
  );

  sbb_target #(.NUM_REGIONS(NUM_REGIONS), .BASE_OFF(BASE_OFF)) tgt_i (
    .clk(clk), .rst_n(rst_n), .sbReq(sbReq), .sbWrite(sbWrite),
    .sbOffset(sbOffset), .sbBe(sbBe), .sbWdata(sbWdata),
    .sbAck(sbAck), .sbErr(sbErr), .sbRdata(sbRdata)
  );
endmodule

// File: tb/sbb_bridge_tb.sv
module sbb_bridge_tb_top;
  localparam logic [7:0] CTRL = 8'hD0;
  localparam logic [7:0] DATA = 8'hD4;
  localparam int K_RD = 0, K_BUSY = 1, K_ERR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        busy, errFlag;

  always #5 clk = ~clk;

  sbb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busy(busy), .errFlag(errFlag)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       expQ[$];
  item_t       curItem;
  logic [31:0] actVal;
  logic        chkReq = 1'b0;
  int          nChecks = 0;
  int          nFails = 0;
  int          cycles = 0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (chkReq && expQ.size() > 0) begin
      curItem = expQ.pop_front();
      case (curItem.kind)
        K_BUSY:  actVal = {31'd0, busy};
        K_ERR:   actVal = {31'd0, errFlag};
        default: actVal = cfgRdData;
      endcase
      nChecks++;
      if (actVal !== curItem.exp) begin
        nFails++;
        $display("FAIL %s: actual %h expected %h", curItem.tag, actVal, curItem.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic expectVal(int kind, logic [7:0] addr, logic [31:0] exp, string tag);
    if (kind == K_RD) cfgAddr = addr;
    expQ.push_back('{kind, exp, tag});
    chkReq = 1'b1;
    @(posedge clk); #1;
    chkReq = 1'b0;
  endtask

  task automatic cfgWrite(logic [7:0] addr, logic [31:0] data);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic cmd(logic [31:0] word);
    cfgWrite(CTRL, word);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(logic [7:0] off, logic [31:0] data, logic [3:0] be);
    cfgWrite(DATA, data);
    cmd({8'hE0, 8'h03, off, be, 4'h0});
  endtask

  task automatic checkReg(logic [7:0] off, logic [31:0] exp, string tag);
    cmd({8'hD0, 8'h03, off, 4'hF, 4'h0});
    expectVal(K_RD, DATA, exp, tag);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    doReset();
    // R12 reset state
    expectVal(K_RD, CTRL, 32'h0, "R12 ctrl after reset");
    expectVal(K_RD, DATA, 32'h0, "R12 data after reset");
    expectVal(K_BUSY, 8'h0, 32'h0, "R12 busy after reset");
    expectVal(K_ERR, 8'h0, 32'h0, "R12 err after reset");

    // R1 register map
    cfgWrite(DATA, 32'h1234_5678);
    expectVal(K_RD, DATA, 32'h1234_5678, "R1 data readback");
    expectVal(K_RD, 8'h40, 32'h0, "R1 unmapped offset reads zero");

    // R6 reset values
    checkReg(8'h15, 32'h0, "R6 region2 high reset");

    // R5 byte enables on region1 high (unlocked)
    regWrite(8'h13, 32'hFFFF_FFFF, 4'h5);
    checkReg(8'h13, 32'h00FF_00FF, "R5 be 0x5");
    regWrite(8'h13, 32'h1122_3344, 4'hA);
    checkReg(8'h13, 32'h11FF_33FF, "R5 be 0xA");

    // R3/R4/R11 write to region0 low with busy timing
    cfgWrite(DATA, 32'hA5A5_0010);
    cfgWrite(CTRL, 32'hE003_10F0);
    expectVal(K_BUSY, 8'h0, 32'h1, "R11 busy first cycle");
    expectVal(K_BUSY, 8'h0, 32'h1, "R11 busy second cycle");
    expectVal(K_BUSY, 8'h0, 32'h0, "R11 busy released");
    cfgWrite(DATA, 32'h0);
    checkReg(8'h10, 32'hA5A5_0010, "R3 R4 write then read region0 low");
    expectVal(K_RD, CTRL, 32'hD003_10F0, "R2 ctrl readback of command word");
    expectVal(K_ERR, 8'h0, 32'h0, "R3 no error on good write");

    // R6 full 32 bits stored in region2 high
    regWrite(8'h15, 32'hDEAD_BEEF, 4'hF);
    checkReg(8'h15, 32'hDEAD_BEEF, "R6 region2 high keeps low nibble");

    // R7 region0 is now locked
    regWrite(8'h10, 32'h0, 4'hF);
    expectVal(K_ERR, 8'h0, 32'h1, "R7 locked write flags error");
    checkReg(8'h10, 32'hA5A5_0010, "R7 locked low unchanged");
    regWrite(8'h11, 32'h55, 4'hF);
    checkReg(8'h11, 32'h0, "R7 locked high unchanged");
    regWrite(8'h12, 32'h0000_0770, 4'hF);
    checkReg(8'h12, 32'h0000_0770, "R7 other region still writable");

    // R7 lock cleared by reset
    doReset();
    checkReg(8'h10, 32'h0, "R6 region0 low zero after reset");
    regWrite(8'h10, 32'h7, 4'hF);
    checkReg(8'h10, 32'h7, "R7 unlocked after reset");
    expectVal(K_ERR, 8'h0, 32'h0, "R12 err cleared by reset");

    // R8 bad opcode
    doReset();
    cfgWrite(DATA, 32'hCAFE_0000);
    cfgWrite(CTRL, 32'h5503_10F0);
    expectVal(K_BUSY, 8'h0, 32'h0, "R8 no busy on bad opcode");
    expectVal(K_ERR, 8'h0, 32'h1, "R8 error on bad opcode");
    expectVal(K_RD, DATA, 32'hCAFE_0000, "R8 data unchanged");
    expectVal(K_RD, CTRL, 32'h5503_10F0, "R2 ctrl holds bad command");
    checkReg(8'h10, 32'h0, "R8 target unchanged");

    // R9 foreign port
    doReset();
    cfgWrite(CTRL, 32'hD005_10F0);
    expectVal(K_BUSY, 8'h0, 32'h0, "R9 no busy on foreign port");
    expectVal(K_RD, DATA, 32'hFFFF_FFFF, "R9 read returns ones");
    expectVal(K_ERR, 8'h0, 32'h1, "R9 error set");

    // R10 unknown offset
    doReset();
    regWrite(8'h16, 32'h1, 4'hF);
    expectVal(K_ERR, 8'h0, 32'h1, "R10 error on unknown offset write");
    cmd(32'hD003_20F0);
    expectVal(K_RD, DATA, 32'hFFFF_FFFF, "R10 unknown offset read ones");
    checkReg(8'h14, 32'h0, "R10 target unchanged");

    // R11 command while busy is dropped
    doReset();
    cfgWrite(DATA, 32'h0000_1111);
    cfgWrEn = 1'b1; cfgAddr = CTRL; cfgWrData = 32'hE003_14F0;
    @(posedge clk); #1;
    cfgWrData = 32'hE003_15F0;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    expectVal(K_BUSY, 8'h0, 32'h1, "R11 still busy on second cycle");
    expectVal(K_BUSY, 8'h0, 32'h0, "R11 busy released after two cycles");
    expectVal(K_ERR, 8'h0, 32'h1, "R11 dropped command flags error");
    expectVal(K_RD, CTRL, 32'hE003_14F0, "R11 ctrl keeps first command");
    checkReg(8'h14, 32'h0000_1111, "R11 first command executed");
    checkReg(8'h15, 32'h0, "R11 second command dropped");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule